// File: doc/BRIEF.md
# Profiling Event Counter Block

This block gives a small processor core a set of free-running profiling counters behind a word-wide register port. A 32-bit clock counter runs while it is enabled. Five 8-bit counters track extra multi-cycle instruction cycles together with fetch stalls, exception-handling cycles, sleep cycles, extra load/store cycles and zero-cycle (folded) instructions. A sample word returns the core's most recent program counter. Each narrow counter signals its wrap with a one-cycle pulse, so a wider accumulator elsewhere can extend it.

Every register write passes through a software lock. The block leaves reset locked. Writing the key value to the lock-access word opens it, and writing any other value to that word closes it again. The clock-counter enable also depends on the global trace enable input: a control write made while that input is low leaves the enable bit as it was.

Word indices on `regSel`: 0 control, 1 clock counter, 2 stall counter, 3 exception counter, 4 sleep counter, 5 load/store counter, 6 fold counter, 7 PC sample, 8 lock access (write-only), 9 lock status (read-only). Reads are combinational from `regSel`. A write takes effect on the clock edge at which `regWrEn` is high.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset the block is locked, all counters read 0, the control word reads 0x40000000 and `ovfPulse` is 0.
- R2: Writing 0xC5ACCE55 to word 8 unlocks the block, and writing any other value to word 8 locks it. Word 9 reads {30'b0, locked, 1'b1}, so it reads 0x3 when locked and 0x1 when unlocked.
- R3: While the block is locked, a write to any word other than word 8 changes nothing.
- R4: Control bit 0 is the clock-counter enable, bit 12 the PC-sample enable and bit 16 the exception-trace enable. Each reads back as written. Bits 27:24 read 0 (all features present). Bits 31:28 read the comparator count, 4 by default. The remaining bits read 0 and ignore writes.
- R5: A control write made while `traceEn` is low leaves bit 0 unchanged, but still updates bits 12 and 16.
- R6: The 32-bit clock counter (word 1) adds one on every clock edge at which control bit 0 is set. A write loads the written value and takes precedence over the increment in that cycle. The counter wraps from 0xFFFFFFFF to 0.
- R7: The stall counter (word 2) adds one on each edge at which `evMultiCycle` or `evFetchStall` is high. It adds only one when both are high.
- R8: The exception, sleep, load/store and fold counters (words 3 to 6) each add one on each edge at which `evException`, `evSleep`, `evLoadStore` or `evFold`, respectively, is high. A write sets the counter to bits 7:0 of the written data, and bits 31:8 read 0.
- R9: When a narrow counter increments from 0xFF to 0x00, `ovfPulse[i]` (i = word − 2) is high for exactly the cycle after that edge.
- R10: Word 7 returns the `pcIn` value captured at the latest clock edge, or 0xFFFFFFFF while `coreHalted` is high. Writes to word 7 are ignored.
- R11: When a write to a narrow counter and that counter's event fall on the same edge, the written value is stored and no increment occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| traceEn | input | 1 | Global trace enable; gates writes to the clock-counter enable |
| coreHalted | input | 1 | Core is halted; PC sample reads all ones |
| pcIn | input | 32 | Current program counter |
| evMultiCycle | input | 1 | Extra cycle of a multi-cycle non-load/store instruction |
| evFetchStall | input | 1 | Instruction fetch stall cycle |
| evException | input | 1 | Cycle spent in exception processing |
| evSleep | input | 1 | Cycle spent sleeping |
| evLoadStore | input | 1 | Extra cycle of a load or store |
| evFold | input | 1 | Instruction completed in zero cycles |
| regSel | input | 4 | Register word index |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the selected word |
| ovfPulse | output | 5 | One-cycle wrap pulse per narrow counter, bit i for word 2+i |

## Verification
A software write and a hardware increment can reach the same counter on the same clock edge. The bench provokes this twice. In the first case the clock counter is loaded with 0xFFFFFFFE while it is running. In the second the load/store event strobe is held high across a write of 0x10 to that counter. The value read right after the write edge must equal the written data exactly, with no extra count, and it must then resume counting (0xFFFFFFFF, then 0) from the loaded value. A wrap test on the fold counter also checks that its overflow pulse lines up with the edge where the counter reads 0.

// File: rtl/perf_counter_pkg.sv
package perf_counter_pkg;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 32;
  localparam int EVT_W   = 8;
  localparam int NUM_EVT = 5;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'hC5AC_CE55;
  localparam logic [3:0]        ABSENT_FLAGS = 4'b0000;

  localparam logic [ADDR_W-1:0] SEL_CTRL      = 4'd0;
  localparam logic [ADDR_W-1:0] SEL_CYC       = 4'd1;
  localparam logic [ADDR_W-1:0] SEL_EVT0      = 4'd2;
  localparam logic [ADDR_W-1:0] SEL_PCS       = 4'd7;
  localparam logic [ADDR_W-1:0] SEL_LOCK_ACC  = 4'd8;
  localparam logic [ADDR_W-1:0] SEL_LOCK_STAT = 4'd9;

  typedef struct packed {
    logic               cycRun;
    logic               ldCyc;
    logic [NUM_EVT-1:0] ldEvt;
  } perfStrobes_t;
endpackage

// File: rtl/perf_counter_ctrl.sv
module perf_counter_ctrl
  import perf_counter_pkg::*;
#(
  parameter int unsigned NUM_CMP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              traceEn,
  input  logic [ADDR_W-1:0] regSel,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output perfStrobes_t      strb,
  output logic [DATA_W-1:0] ctrlRd,
  output logic              locked
);
  logic cycEnaQ, pcSampQ, excTrcQ;
  logic wrOk;

  assign wrOk = regWrEn && !locked;

  // lock access word is always writable; key opens, anything else closes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked <= 1'b1;
    end else if (regWrEn && regSel == SEL_LOCK_ACC) begin
      locked <= (regWrData != UNLOCK_KEY);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycEnaQ <= 1'b0;
      pcSampQ <= 1'b0;
      excTrcQ <= 1'b0;
    end else if (wrOk && regSel == SEL_CTRL) begin
      pcSampQ <= regWrData[12];
      excTrcQ <= regWrData[16];
      if (traceEn) cycEnaQ <= regWrData[0];
    end
  end

  always_comb begin
    strb.cycRun = cycEnaQ;
    strb.ldCyc  = wrOk && (regSel == SEL_CYC);
    for (int i = 0; i < NUM_EVT; i++) begin
      strb.ldEvt[i] = wrOk && (regSel == SEL_EVT0 + ADDR_W'(i));
    end
  end

  assign ctrlRd = {4'(NUM_CMP), ABSENT_FLAGS, 7'b0, excTrcQ, 3'b0, pcSampQ, 11'b0, cycEnaQ};
endmodule

// File: rtl/perf_counter_dp.sv
module perf_counter_dp
  import perf_counter_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  perfStrobes_t       strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_EVT-1:0] evtVec,
  input  logic [DATA_W-1:0]  pcIn,
  input  logic               coreHalted,
  input  logic [ADDR_W-1:0]  regSel,
  input  logic [DATA_W-1:0]  ctrlRd,
  input  logic               locked,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_EVT-1:0] ovfPulse,
  output logic [DATA_W-1:0]  cycCount
);
  logic [EVT_W-1:0]  evtCnt [NUM_EVT];
  logic [DATA_W-1:0] pcLast;

  always_ff @(posedge clk) begin
    if (!rstN)           cycCount <= '0;
    else if (strb.ldCyc) cycCount <= wrData;
    else if (strb.cycRun) cycCount <= cycCount + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pcLast <= '0;
    else       pcLast <= pcIn;
  end

  for (genvar g = 0; g < NUM_EVT; g++) begin : gEvt
    always_ff @(posedge clk) begin
      if (!rstN) begin
        evtCnt[g]   <= '0;
        ovfPulse[g] <= 1'b0;
      end else begin
        ovfPulse[g] <= 1'b0;
        if (strb.ldEvt[g]) begin
          evtCnt[g] <= wrData[EVT_W-1:0];
        end else if (evtVec[g]) begin
          evtCnt[g]   <= evtCnt[g] + 1'b1;
          ovfPulse[g] <= &evtCnt[g];
        end
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (regSel)
      SEL_CTRL:      rdData = ctrlRd;
      SEL_CYC:       rdData = cycCount;
      SEL_PCS:       rdData = coreHalted ? '1 : pcLast;
      SEL_LOCK_STAT: rdData = {{(DATA_W-2){1'b0}}, locked, 1'b1};
      default:       rdData = '0;
    endcase
    for (int i = 0; i < NUM_EVT; i++) begin
      if (regSel == SEL_EVT0 + ADDR_W'(i)) rdData = {{(DATA_W-EVT_W){1'b0}}, evtCnt[i]};
    end
  end
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
  import perf_counter_pkg::*;
#(
  parameter int unsigned NUM_CMP = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               traceEn,
  input  logic               coreHalted,
  input  logic [DATA_W-1:0]  pcIn,
  input  logic               evMultiCycle,
  input  logic               evFetchStall,
  input  logic               evException,
  input  logic               evSleep,
  input  logic               evLoadStore,
  input  logic               evFold,
  input  logic [ADDR_W-1:0]  regSel,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic [NUM_EVT-1:0] ovfPulse
);
  perfStrobes_t       strb;
  logic [DATA_W-1:0]  ctrlRd;
  logic [DATA_W-1:0]  cycCount;
  logic               locked;
  logic [NUM_EVT-1:0] evtVec;

  // bit i feeds the counter at word 2+i
  assign evtVec = {evFold, evLoadStore, evSleep, evException, evMultiCycle | evFetchStall};

  perf_counter_ctrl #(.NUM_CMP(NUM_CMP)) uCtrl (
    .clk(clk), .rstN(rstN), .traceEn(traceEn), .regSel(regSel),
    .regWrEn(regWrEn), .regWrData(regWrData), .strb(strb),
    .ctrlRd(ctrlRd), .locked(locked)
  );

  perf_counter_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData), .evtVec(evtVec),
    .pcIn(pcIn), .coreHalted(coreHalted), .regSel(regSel), .ctrlRd(ctrlRd),
    .locked(locked), .rdData(regRdData), .ovfPulse(ovfPulse), .cycCount(cycCount)
  );
endmodule

// File: rtl/perf_counter_checks.sv
module perf_counter_checks
  import perf_counter_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               traceEn,
  input logic               coreHalted,
  input logic [ADDR_W-1:0]  regSel,
  input logic               regWrEn,
  input logic [DATA_W-1:0]  regWrData,
  input logic [DATA_W-1:0]  regRdData,
  input logic [NUM_EVT-1:0] ovfPulse,
  input logic               locked,
  input logic [DATA_W-1:0]  ctrlRd,
  input logic [DATA_W-1:0]  cycCount,
  input perfStrobes_t       strb
);
  assert_unlock_key_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == SEL_LOCK_ACC && regWrData == UNLOCK_KEY) |=> !locked);

  assert_relock_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == SEL_LOCK_ACC && regWrData != UNLOCK_KEY) |=> locked);

  assert_locked_ctrl_R3: assert property (@(posedge clk) disable iff (!rstN)
    (locked && regWrEn && regSel == SEL_CTRL) |=> $stable(ctrlRd));

  assert_trace_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == SEL_CTRL && !traceEn) |=> ctrlRd[0] == $past(ctrlRd[0]));

  assert_cyc_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cycRun && !(regWrEn && !locked && regSel == SEL_CYC)) |=> cycCount == $past(cycCount) + 32'd1);

  assert_ovf_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ovfPulse != '0) |=> (ovfPulse == '0));

  assert_halt_pc_R10: assert property (@(posedge clk) disable iff (!rstN)
    (coreHalted && regSel == SEL_PCS) |-> regRdData == '1);
endmodule

bind perf_counter_unit perf_counter_checks chk (
  .clk(clk), .rstN(rstN), .traceEn(traceEn), .coreHalted(coreHalted),
  .regSel(regSel), .regWrEn(regWrEn), .regWrData(regWrData),
  .regRdData(regRdData), .ovfPulse(ovfPulse), .locked(locked),
  .ctrlRd(ctrlRd), .cycCount(cycCount), .strb(strb)
);

// File: tb/perf_counter_unit_test.sv
`timescale 1ns/1ps
module perf_counter_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        traceEn = 1'b0;
  logic        coreHalted = 1'b0;
  logic [31:0] pcIn = '0;
  logic        evMultiCycle = 1'b0, evFetchStall = 1'b0, evException = 1'b0;
  logic        evSleep = 1'b0, evLoadStore = 1'b0, evFold = 1'b0;
  logic [3:0]  regSel = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [4:0]  ovfPulse;

  int nChecks = 0;
  int nErr = 0;

  always #2 clk = ~clk;

  perf_counter_unit uut (
    .clk(clk), .rstN(rstN), .traceEn(traceEn), .coreHalted(coreHalted), .pcIn(pcIn),
    .evMultiCycle(evMultiCycle), .evFetchStall(evFetchStall), .evException(evException),
    .evSleep(evSleep), .evLoadStore(evLoadStore), .evFold(evFold),
    .regSel(regSel), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .ovfPulse(ovfPulse)
  );

  // {sel[3:0], traceEn, wrData[31:0], expected readback[31:0]}
  localparam int NVEC = 9;
  localparam logic [68:0] VEC [NVEC] = '{
    {4'd0, 1'b1, 32'hFFFF_FFFF, 32'h4001_1001},  // R4
    {4'd0, 1'b0, 32'h0000_0000, 32'h4000_0001},  // R5
    {4'd0, 1'b1, 32'h0000_0000, 32'h4000_0000},  // R4
    {4'd1, 1'b1, 32'h1234_5678, 32'h1234_5678},  // R6
    {4'd2, 1'b1, 32'h0000_01AB, 32'h0000_00AB},  // R8
    {4'd3, 1'b1, 32'h0000_0055, 32'h0000_0055},  // R8
    {4'd4, 1'b1, 32'h00FF_FF00, 32'h0000_0000},  // R8
    {4'd5, 1'b1, 32'h0000_007F, 32'h0000_007F},  // R8
    {4'd6, 1'b1, 32'h0000_0080, 32'h0000_0080}   // R8
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    regSel = s; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s, output logic [31:0] v);
    regSel = s;
    #0.5;
    v = regRdData;
  endtask

  task automatic pulse(input logic [5:0] ev, input int n);
    @(negedge clk);
    {evFold, evLoadStore, evSleep, evException, evFetchStall, evMultiCycle} = ev;
    repeat (n) @(negedge clk);
    {evFold, evLoadStore, evSleep, evException, evFetchStall, evMultiCycle} = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] v, w;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, v); check("R1 ctrl", v, 32'h4000_0000);
    rd(4'd1, v); check("R1 cyc", v, 32'h0);
    rd(4'd2, v); check("R1 stall cnt", v, 32'h0);
    rd(4'd9, v); check("R1 lock status", v, 32'h3);
    check("R1 ovf", {27'b0, ovfPulse}, 32'h0);

    // R3 writes ignored while locked
    traceEn = 1'b1;
    doWrite(4'd0, 32'h0001_1001);
    rd(4'd0, v); check("R3 ctrl locked", v, 32'h4000_0000);
    doWrite(4'd2, 32'h33);
    rd(4'd2, v); check("R3 cnt locked", v, 32'h0);

    // R2 lock handling
    doWrite(4'd8, 32'hC5AC_CE54);
    rd(4'd9, v); check("R2 wrong key", v, 32'h3);
    doWrite(4'd8, 32'hC5AC_CE55);
    rd(4'd9, v); check("R2 unlocked", v, 32'h1);

    // table walk: write then read back
    for (int i = 0; i < NVEC; i++) begin
      traceEn = VEC[i][64];
      doWrite(VEC[i][68:65], VEC[i][63:32]);
      rd(VEC[i][68:65], v);
      check($sformatf("R4/R5/R6/R8 vec%0d", i), v, VEC[i][31:0]);
    end
    traceEn = 1'b1;

    // R6 run, load while running, wrap
    doWrite(4'd0, 32'h1);
    doWrite(4'd1, 32'hFFFF_FFFE);
    rd(4'd1, v); check("R6 load while running", v, 32'hFFFF_FFFE);
    @(negedge clk); rd(4'd1, v); check("R6 step", v, 32'hFFFF_FFFF);
    @(negedge clk); rd(4'd1, v); check("R6 wrap", v, 32'h0);
    doWrite(4'd0, 32'h0);
    rd(4'd1, v);
    @(negedge clk); rd(4'd1, w); check("R6 halted when disabled", w, v);

    // R7 stall counter, both strobes count once
    pulse(6'b000001, 3);
    pulse(6'b000011, 2);
    pulse(6'b000010, 1);
    rd(4'd2, v); check("R7 stall cnt", v, 32'h0000_00B1);

    // R8 other counters
    pulse(6'b000100, 4); rd(4'd3, v); check("R8 exc cnt", v, 32'h59);
    pulse(6'b001000, 2); rd(4'd4, v); check("R8 sleep cnt", v, 32'h02);
    pulse(6'b010000, 1); rd(4'd5, v); check("R8 lsu cnt", v, 32'h80);
    pulse(6'b100000, 5); rd(4'd6, v); check("R8 fold cnt", v, 32'h85);

    // R9 wrap pulse on fold counter
    doWrite(4'd6, 32'hFF);
    evFold = 1'b1;
    @(posedge clk); #0.5;
    check("R9 ovf pulse", {27'b0, ovfPulse}, 32'h10);
    rd(4'd6, v); check("R9 wrapped", v, 32'h0);
    @(negedge clk); evFold = 1'b0;
    @(posedge clk); #0.5;
    check("R9 pulse one cycle", {27'b0, ovfPulse}, 32'h0);
    @(negedge clk);

    // R11 write collides with event
    evLoadStore = 1'b1;
    doWrite(4'd5, 32'h10);
    rd(4'd5, v); check("R11 write wins", v, 32'h10);
    evLoadStore = 1'b0;

    // R10 PC sample
    pcIn = 32'h1000_0040;
    doWrite(4'd7, 32'h0);
    rd(4'd7, v); check("R10 pc sample", v, 32'h1000_0040);
    coreHalted = 1'b1;
    rd(4'd7, v); check("R10 halted", v, 32'hFFFF_FFFF);
    coreHalted = 1'b0;

    // R2 relock, then R3 again
    doWrite(4'd8, 32'h0);
    rd(4'd9, v); check("R2 relocked", v, 32'h3);
    doWrite(4'd0, 32'h0001_0000);
    rd(4'd0, v); check("R3 ctrl relocked", v, 32'h4000_0000);

    $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule